// File: doc/BRIEF.md
# 1-Wire Reset and Presence Sequencer

This block runs the reset phase of a 1-Wire bus. When it receives a start pulse it pulls the open-drain line low for the reset period and then lets it go. It then watches the line for a device that answers with a presence pulse. It does not report completion until two conditions hold: a minimum busy window, measured from the moment it first pulled the line, has elapsed, and the line has been idle high for a recovery interval.

Sometimes the line stays low after release. The cause may be a device that is signalling an alarm or a short to ground. In that case the block waits a bounded time for the line to rise. If the line rises, presence monitoring continues as normal. If the wait expires, the block flags the bus as shorted and finishes.

All durations are counted in ticks of a 1 µs enable. The raw bus input passes through a synchronizer before any logic uses it. An overdrive select, captured at start, divides every duration by a parameter factor.

Top module: `owire_rst_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `bus_pull`, `busy`, `done`, `present` and `shorted` are all 0.
- R2: A `start` seen while idle sets `bus_pull` and `busy` on the next cycle. `bus_pull` then stays high for exactly RST_LOW_US ticks (default 480).
- R3: `done` is a one-cycle pulse. `busy` falls in the same cycle. `done` never comes fewer than MIN_BUSY_US ticks (default 960) after the start was captured.
- R4: `present` is 1 when the synchronized bus was seen low at any point after it first returned high following release in the current sequence. `present` and `shorted` hold their values from `done` until the next accepted start.
- R5: `done` is not signalled until the synchronized bus has been continuously high for IDLE_US ticks (default 180).
- R6: If the bus is still low after release, the block waits up to ALARM_US ticks (default 3840) for it to rise. If it rises within that time, presence monitoring and the idle rule apply as in R4 and R5, and `shorted` stays 0.
- R7: If the wait in R6 expires, `done` pulses exactly ALARM_US ticks after release, with `shorted` = 1 and `present` = 0.
- R8: A `start` that arrives while `busy` is 1 has no effect. The sequence already running produces exactly one `done` at its normal time.
- R9: Time advances only on cycles with `us_tick` high. With a tick on every other cycle, every duration doubles in clock cycles.
- R10: When `od_sel` is 1 at the accepted start, every duration is divided by OD_DIV (default 8). This gives 60, 120, 22 and 480 ticks.
- R11: `bus_pull` rises exactly once per sequence and is never reasserted after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle enable every microsecond |
| start | input | 1 | Request a reset sequence (accepted while idle) |
| od_sel | input | 1 | Overdrive timing select, captured at start |
| bus_in | input | 1 | Raw bus level, asynchronous |
| bus_pull | output | 1 | Open-drain enable; 1 pulls the bus low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| present | output | 1 | A presence response was seen |
| shorted | output | 1 | Bus did not release within the alarm wait |

## Verification
Every result is due a fixed number of cycles after the edge that captures `start`. `bus_pull` rises one cycle after that edge. In the normal case `done` follows 961 cycles later. On a timeout, `done` comes exactly RST_LOW_US + ALARM_US cycles after the start. When a device or a long alarm sets the timing, the bus rise plus IDLE_US plus the two synchronizer stages fixes `done` to within a few cycles. The driver records the capturing edge and queues a latency window for each case: exact where the path is fixed, a few cycles wide where it passes through the synchronizer. It also queues the expected flags and the pull width. The monitor samples on falling edges and, on each `done`, measures the latency from that edge and compares all of these.

// File: rtl/owrs_pkg.sv
package owrs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAIT_HI,
    ST_MON
  } owrs_state_e;

  function automatic int owrs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int owrs_scale(input int val, input int div);
    return owrs_max(1, val / div);
  endfunction

endpackage

// File: rtl/owrs_sync.sv
module owrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/owrs_timer.sv
module owrs_timer #(
  parameter int W   = 10,
  parameter int MAX = 960
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (tick && cnt != CMAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/owrs_limits.sv
module owrs_limits #(
  parameter int RST_LOW_US  = 480,
  parameter int MIN_BUSY_US = 960,
  parameter int IDLE_US     = 180,
  parameter int ALARM_US    = 3840,
  parameter int OD_DIV      = 8,
  parameter int PW          = 12,
  parameter int TW          = 10,
  parameter int IW          = 8
) (
  input  logic          od,
  output logic [PW-1:0] lim_low,
  output logic [PW-1:0] lim_alarm,
  output logic [TW-1:0] lim_min,
  output logic [IW-1:0] lim_idle
);
  import owrs_pkg::*;

  localparam logic [PW-1:0] N_LOW   = PW'(RST_LOW_US);
  localparam logic [PW-1:0] N_ALARM = PW'(ALARM_US);
  localparam logic [TW-1:0] N_MIN   = TW'(MIN_BUSY_US);
  localparam logic [IW-1:0] N_IDLE  = IW'(IDLE_US);

  generate
    if (OD_DIV > 1) begin : g_od
      localparam logic [PW-1:0] O_LOW   = PW'(owrs_scale(RST_LOW_US, OD_DIV));
      localparam logic [PW-1:0] O_ALARM = PW'(owrs_scale(ALARM_US, OD_DIV));
      localparam logic [TW-1:0] O_MIN   = TW'(owrs_scale(MIN_BUSY_US, OD_DIV));
      localparam logic [IW-1:0] O_IDLE  = IW'(owrs_scale(IDLE_US, OD_DIV));
      assign lim_low   = od ? O_LOW   : N_LOW;
      assign lim_alarm = od ? O_ALARM : N_ALARM;
      assign lim_min   = od ? O_MIN   : N_MIN;
      assign lim_idle  = od ? O_IDLE  : N_IDLE;
    end else begin : g_std
      assign lim_low   = N_LOW;
      assign lim_alarm = N_ALARM;
      assign lim_min   = N_MIN;
      assign lim_idle  = N_IDLE;
    end
  endgenerate
endmodule

// File: rtl/owire_rst_seq.sv
module owire_rst_seq #(
  parameter int RST_LOW_US  = 480,
  parameter int MIN_BUSY_US = 960,
  parameter int IDLE_US     = 180,
  parameter int ALARM_US    = 3840,
  parameter int OD_DIV      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic us_tick,
  input  logic start,
  input  logic od_sel,
  input  logic bus_in,
  output logic bus_pull,
  output logic busy,
  output logic done,
  output logic present,
  output logic shorted
);
  import owrs_pkg::*;

  localparam int PW = $clog2(owrs_max(ALARM_US, RST_LOW_US) + 1);
  localparam int TW = $clog2(MIN_BUSY_US + 1);
  localparam int IW = $clog2(IDLE_US + 1);

  owrs_state_e   state;
  logic          od_q;
  logic          bus_s;
  logic [PW-1:0] ph_cnt;
  logic [TW-1:0] tot_cnt;
  logic [IW-1:0] id_cnt;
  logic [PW-1:0] lim_low, lim_alarm;
  logic [TW-1:0] lim_min;
  logic [IW-1:0] lim_idle;
  logic          accept, rel_now, alarm_end, mon_ok;

  owrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(bus_in), .q(bus_s)
  );

  owrs_limits #(
    .RST_LOW_US(RST_LOW_US), .MIN_BUSY_US(MIN_BUSY_US), .IDLE_US(IDLE_US),
    .ALARM_US(ALARM_US), .OD_DIV(OD_DIV), .PW(PW), .TW(TW), .IW(IW)
  ) u_lim (
    .od(od_q), .lim_low(lim_low), .lim_alarm(lim_alarm),
    .lim_min(lim_min), .lim_idle(lim_idle)
  );

  assign accept    = (state == ST_IDLE) && start;
  assign rel_now   = (state == ST_LOW) && us_tick && (ph_cnt == lim_low - PW'(1));
  assign alarm_end = us_tick && (ph_cnt == lim_alarm - PW'(1));
  assign mon_ok    = (tot_cnt >= lim_min) && (id_cnt >= lim_idle);

  // phase timer: reset low time, then the alarm wait after release
  owrs_timer #(.W(PW), .MAX(owrs_max(ALARM_US, RST_LOW_US))) u_ph (
    .clk(clk), .rst(rst), .clr(accept || rel_now), .tick(us_tick), .cnt(ph_cnt)
  );

  // total busy time measured from the first pull
  owrs_timer #(.W(TW), .MAX(MIN_BUSY_US)) u_tot (
    .clk(clk), .rst(rst), .clr(accept), .tick(us_tick), .cnt(tot_cnt)
  );

  // continuous idle-high time while monitoring
  owrs_timer #(.W(IW), .MAX(IDLE_US)) u_idle (
    .clk(clk), .rst(rst), .clr((state != ST_MON) || !bus_s),
    .tick(us_tick), .cnt(id_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      od_q     <= 1'b0;
      bus_pull <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      present  <= 1'b0;
      shorted  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_LOW;
            od_q     <= od_sel;
            bus_pull <= 1'b1;
            busy     <= 1'b1;
            present  <= 1'b0;
            shorted  <= 1'b0;
          end
        end
        ST_LOW: begin
          if (rel_now) begin
            bus_pull <= 1'b0;
            state    <= ST_WAIT_HI;
          end
        end
        ST_WAIT_HI: begin
          if (bus_s) begin
            state <= ST_MON;
          end else if (alarm_end) begin
            shorted <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_MON: begin
          if (!bus_s) begin
            present <= 1'b1;
          end else if (mon_ok) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owrs_chk.sv
module owrs_chk #(
  parameter int MIN_BUSY_US = 960,
  parameter int OD_DIV      = 8
) (
  input logic clk,
  input logic rst,
  input logic bus_pull,
  input logic busy,
  input logic done,
  input logic present,
  input logic shorted,
  input logic od_q
);
  localparam int MIN_OD = (MIN_BUSY_US / OD_DIV > 0) ? MIN_BUSY_US / OD_DIV : 1;

  int unsigned bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  p_pull_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    bus_pull |-> busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_frees_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_min_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (bcnt >= (od_q ? MIN_OD : MIN_BUSY_US)));

  p_flags_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (busy || ($stable(present) && $stable(shorted))));

  p_short_nopres_r7: assert property (@(posedge clk) disable iff (rst)
    shorted |-> !present);

  p_no_repull_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_pull) |=> !bus_pull);
endmodule

bind owire_rst_seq owrs_chk #(
  .MIN_BUSY_US(MIN_BUSY_US), .OD_DIV(OD_DIV)
) u_chk (
  .clk(clk), .rst(rst), .bus_pull(bus_pull), .busy(busy), .done(done),
  .present(present), .shorted(shorted), .od_q(od_q)
);

// File: tb/owire_rst_seq_bench.sv
module owire_rst_seq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit pres;
    bit shrt;
    int lat_lo;
    int lat_hi;
    int pw_lo;
    int pw_hi;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic us_tick = 1;
  logic start = 0;
  logic od_sel = 0;
  logic dev_pull = 0;
  logic bus_in, bus_pull, busy, done, present, shorted;

  int cyc = 0;
  int st_cyc = 0;
  int done_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  assign bus_in = !(bus_pull || dev_pull);

  owire_rst_seq u_owire_rst_seq (
    .clk(clk), .rst(rst), .us_tick(us_tick), .start(start), .od_sel(od_sel),
    .bus_in(bus_in), .bus_pull(bus_pull), .busy(busy), .done(done),
    .present(present), .shorted(shorted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk_int(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // monitor: measures pull width and pulse count, scores each done
  int  pw = 0;
  int  rises = 0;
  bit  pull_prev = 0;
  always @(negedge clk) begin
    exp_t  e;
    string t;
    if (rst) begin
      pw = 0; rises = 0; pull_prev = 0;
    end else begin
      if (bus_pull && !pull_prev) begin pw = 1; rises++; end
      else if (bus_pull) pw++;
      pull_prev = bus_pull;
      if (done) begin
        if (exp_q.size() == 0) begin
          chk_int("R8", "unexpected done", 1, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk_int(t, "present", present, e.pres);
          chk_int(t, "shorted", shorted, e.shrt);
          chk_rng(t, "done latency", cyc - st_cyc, e.lat_lo, e.lat_hi);
          chk_rng(t, "pull width", pw, e.pw_lo, e.pw_hi);
          chk_int("R11", "pull pulses", rises, 1);
          chk_int(t, "busy with done", busy, 0);
        end
        rises = 0;
        done_cnt++;
      end
    end
  end

  task automatic run_seq(input string tag, input bit od, input bit half,
                         input int dly, input int plen, input int hold,
                         input bit shrt, input bit poke,
                         input bit e_pres, input bit e_shrt,
                         input int llo, input int lhi, input int plo, input int phi);
    exp_t e;
    int   d0;
    int   k;
    int   rel_k;
    bit   go;
    e.pres = e_pres; e.shrt = e_shrt;
    e.lat_lo = llo; e.lat_hi = lhi; e.pw_lo = plo; e.pw_hi = phi;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    d0 = done_cnt;
    rel_k = -1;
    @(negedge clk);
    od_sel = od; start = 1; st_cyc = cyc + 1; us_tick = 1;
    dev_pull = shrt || (hold > 0);
    go = 1;
    while (go) begin
      @(negedge clk);
      k = cyc - st_cyc;
      start = poke && (k == 300);
      us_tick = !half || (k % 2 == 1);
      if (rel_k < 0 && !bus_pull) rel_k = k;
      dev_pull = shrt || (k < hold) ||
                 (rel_k >= 0 && plen > 0 && (k - rel_k) >= dly && (k - rel_k) < dly + plen);
      if (done_cnt != d0) go = 0;
      if (k > 20000) begin
        chk_int(tag, "sequence finished", 0, 1);
        go = 0;
      end
    end
    start = 0; dev_pull = 0; us_tick = 1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk_int("R1", "bus_pull in reset", bus_pull, 0);
    chk_int("R1", "busy in reset", busy, 0);
    rst = 0;
    @(negedge clk);
    chk_int("R1", "bus_pull after reset", bus_pull, 0);
    chk_int("R1", "busy after reset", busy, 0);
    chk_int("R1", "done after reset", done, 0);
    chk_int("R1", "present after reset", present, 0);
    chk_int("R1", "shorted after reset", shorted, 0);

    // R2 R3: empty bus, normal timing
    run_seq("R2/R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 961, 963, 480, 480);
    // R4: device answers 30 us after release for 120 us
    run_seq("R4", 0, 0, 30, 120, 0, 0, 0, 1, 0, 961, 963, 480, 480);
    chk_int("R4", "present held after done", present, 1);
    // R5: long presence pulse, idle window sets done
    run_seq("R5", 0, 0, 60, 400, 0, 0, 0, 1, 0, 1120, 1132, 480, 480);
    // R8: start poked mid-sequence is ignored
    run_seq("R8", 0, 0, 0, 0, 0, 0, 1, 0, 0, 961, 963, 480, 480);
    chk_int("R8", "no restart after done", busy, 0);
    // R6: bus held low until 1480, then released
    run_seq("R6", 0, 0, 0, 0, 1480, 0, 0, 0, 0, 1660, 1672, 480, 480);
    // R7: bus never released
    run_seq("R7", 0, 0, 0, 0, 0, 1, 0, 0, 1, 4320, 4320, 480, 480);
    chk_int("R7", "pull released after short", bus_pull, 0);
    // R10: overdrive presence
    run_seq("R10", 1, 0, 8, 32, 0, 0, 0, 1, 0, 121, 130, 60, 60);
    // R10 R7: overdrive short
    run_seq("R10/R7", 1, 0, 0, 0, 0, 1, 0, 0, 1, 540, 540, 60, 60);
    // R9: tick on every other cycle
    run_seq("R9", 0, 1, 0, 0, 0, 0, 0, 0, 0, 1919, 1926, 958, 962);

    chk_int("R8", "pending expectations", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule